// File: doc/BRIEF.md
# Serial Controller Processor Interface

This block is the processor-side front end of a serial communication controller. A host reaches it through an 8-bit write bus and an 8-bit read bus, with an active-low chip select, active-low read and write strobes, and a select line that chooses between the data path and the control path. The control path has one address that is used in sequence. The first control write after reset, or after an internal-reset command, is taken as the mode byte. Every control write after that is a command byte.

The block passes the mode fields, the transmit and receive enables, the break request, an error-clear pulse and a hunt request to the serial engines. It drives the active-low terminal-ready and request-to-send modem lines from command bits. It holds one transmit character and one received character. It keeps sticky parity, overrun and framing flags. A status read returns these flags together with the synchronised data-set-ready input and the sync-detect flag from the receiver.

Each access acts once, on the first clock cycle in which the strobe is active. The one exception is a data read, whose side effect happens when the strobe is released.

Top module: `usart_cpu_if`

## Requirements
- R1: While `rst_n` is low, and after it is released, the block waits for a mode byte. In this state `mode_valid`, `tx_en`, `rx_en` and `send_brk` are 0, `dtr_n` and `rts_n` are 1, and with the transmitter idle a status read returns 8'h05.
- R2: An access takes effect only while `cs_n` is low. A write strobe with `cs_n` high changes nothing, and a read strobe with `cs_n` high returns zero.
- R3: The first control write (`cd`=1) while waiting for a mode byte loads the mode and sets `mode_valid`. The mode fields are:
  - bits [7:6] stop length: 01 one, 10 one and a half, 11 two.
  - bit [5] parity sense: 1 even, 0 odd.
  - bit [4] parity enable.
  - bits [3:2] character length: five plus the field value.
  - bits [1:0] clock factor: 00 synchronous, 01 x1, 10 x16, 11 x64.
- R4: Control writes made while `mode_valid` is 1 are commands. Bit 0 sets `tx_en`, bit 2 sets `rx_en` and bit 3 sets `send_brk`. Each command byte replaces these levels, and the mode is left unchanged.
- R5: Command bit 1 drives `dtr_n` low and command bit 5 drives `rts_n` low. A later command with the bit clear returns the line high.
- R6: A command with bit 6 set clears all command levels and clears `mode_valid`, so the next control write is taken as a mode byte again.
- R7: Command bit 4 gives a one-cycle `err_clr` pulse in the cycle after the write. That pulse clears the parity, overrun and framing flags. It does not stay latched, so later errors set the flags again.
- R8: Command bit 7 gives a one-cycle `hunt_req` pulse in the cycle after the write.
- R9: A data write loads `tx_hold_data` and sets `tx_hold_valid` until `tx_take` is pulsed. Status bit 0 (TxRDY) is the inverse of `tx_hold_valid`. Status bit 2 (TxEMPTY) is 1 only when nothing is held and `tx_idle` is 1.
- R10: An `rx_valid` pulse while `rx_en` is 1 stores `rx_char` and sets status bit 1 (RxRDY). With `rx_en` at 0 the pulse is ignored.
- R11: A data read returns the stored character. RxRDY clears on the clock edge after the read strobe is released.
- R12: A character accepted while RxRDY is set sets overrun (status bit 4). `rx_perr` sets parity error (bit 3) and `rx_ferr` sets framing error (bit 5). All three flags are sticky.
- R13: Status bit 7 is the inverse of `dsr_n` after `SYNC_STAGES` clock edges, and bit 6 follows `syndet`.
- R14: `dout` is zero whenever no read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| cd | input | 1 | 1 control/status, 0 data |
| din | input | 8 | Write data bus |
| dout | output | 8 | Read data bus |
| stop_bits | output | 2 | Stop length field |
| parity_even | output | 1 | Parity sense |
| parity_en | output | 1 | Parity enable |
| char_len | output | 2 | Character length field |
| clk_factor | output | 2 | Clock factor field |
| mode_valid | output | 1 | Mode byte received |
| tx_en | output | 1 | Transmit enable |
| rx_en | output | 1 | Receive enable |
| send_brk | output | 1 | Send break request |
| err_clr | output | 1 | Error-clear pulse |
| hunt_req | output | 1 | Hunt request pulse |
| dtr_n | output | 1 | Terminal ready, active low |
| rts_n | output | 1 | Request to send, active low |
| tx_hold_data | output | 8 | Held transmit character |
| tx_hold_valid | output | 1 | Transmit character waiting |
| tx_take | input | 1 | Transmitter took the character |
| tx_idle | input | 1 | Transmit shifter idle |
| rx_valid | input | 1 | Received character strobe |
| rx_char | input | 8 | Received character |
| rx_perr | input | 1 | Parity error with character |
| rx_ferr | input | 1 | Framing error with character |
| dsr_n | input | 1 | Data set ready, active low, asynchronous |
| syndet | input | 1 | Sync-detect flag from receiver |

## Verification
The bench builds the block with `SYNC_STAGES` set to 3 and `RST_STAGES` left at 2. The deeper synchroniser lets the bench read status once before the modem input has crossed and once after. That separates the latency in R13 from a plain pass-through. The reset depth of 2 keeps the release short, so the reset-state checks run soon after reset. A table of mode bytes revisits R3 through repeated internal resets.

// File: rtl/usart_if_pkg.sv
package usart_if_pkg;

  localparam int BYTE_W = 8;

  // command bit positions (behavioural: software sets them by position)
  localparam int CMD_TXEN = 0;
  localparam int CMD_DTR  = 1;
  localparam int CMD_RXEN = 2;
  localparam int CMD_BRK  = 3;
  localparam int CMD_ERR  = 4;
  localparam int CMD_RTS  = 5;
  localparam int CMD_IRST = 6;
  localparam int CMD_HUNT = 7;

  // packed order equals the mode byte layout, MSB first
  typedef struct packed {
    logic [1:0] stop;
    logic       par_even;
    logic       par_en;
    logic [1:0] len;
    logic [1:0] factor;
  } mode_t;

  typedef struct packed {
    logic rts;
    logic brk;
    logic rx_en;
    logic dtr;
    logic tx_en;
  } cmd_t;

  // packed order equals the status byte layout, MSB first
  typedef struct packed {
    logic dsr;
    logic syndet;
    logic fe;
    logic oe;
    logic pe;
    logic txempty;
    logic rxrdy;
    logic txrdy;
  } status_t;

endpackage

// File: rtl/usart_rst_sync.sv
module usart_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/usart_sync_bit.sv
module usart_sync_bit #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= {STAGES{RST_VAL}};
    else        sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];

endmodule

// File: rtl/usart_bus_ctl.sv
module usart_bus_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic rd_n,
  input  logic wr_n,
  input  logic cd,
  output logic ctrl_wr,
  output logic data_wr,
  output logic rd_ctrl_sel,
  output logic rd_data_sel,
  output logic data_rd_done
);

  logic wr_act;
  logic rd_act;
  logic wr_act_q;
  logic rd_data_q;

  // a write strobe blocks a read if both are low
  always_comb begin
    wr_act       = ~cs_n & ~wr_n;
    rd_act       = ~cs_n & ~rd_n & wr_n;
    rd_ctrl_sel  = rd_act & cd;
    rd_data_sel  = rd_act & ~cd;
    ctrl_wr      = wr_act & ~wr_act_q & cd;
    data_wr      = wr_act & ~wr_act_q & ~cd;
    data_rd_done = rd_data_q & ~rd_data_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_act_q  <= 1'b0;
      rd_data_q <= 1'b0;
    end else begin
      wr_act_q  <= wr_act;
      rd_data_q <= rd_data_sel;
    end
  end

endmodule

// File: rtl/usart_ctrl_regs.sv
module usart_ctrl_regs
  import usart_if_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [BYTE_W-1:0] wdata,
  output mode_t             mode,
  output logic              mode_valid,
  output cmd_t              cmd,
  output logic              err_clr,
  output logic              hunt_req
);

  logic  await_q, await_d;
  logic  mode_en, cmd_en, irst;
  mode_t mode_q;
  cmd_t  cmd_q, cmd_d;
  logic  err_q, err_d;
  logic  hunt_q, hunt_d;

  always_comb begin
    mode_en = ctrl_wr & await_q;
    cmd_en  = ctrl_wr & ~await_q;
    irst    = cmd_en & wdata[CMD_IRST];

    await_d = await_q;
    if (mode_en)   await_d = 1'b0;
    else if (irst) await_d = 1'b1;

    cmd_d = cmd_q;
    if (irst) begin
      cmd_d = '0;
    end else if (cmd_en) begin
      cmd_d.tx_en = wdata[CMD_TXEN];
      cmd_d.dtr   = wdata[CMD_DTR];
      cmd_d.rx_en = wdata[CMD_RXEN];
      cmd_d.brk   = wdata[CMD_BRK];
      cmd_d.rts   = wdata[CMD_RTS];
    end

    err_d  = cmd_en & ~wdata[CMD_IRST] & wdata[CMD_ERR];
    hunt_d = cmd_en & ~wdata[CMD_IRST] & wdata[CMD_HUNT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      await_q <= 1'b1;
      cmd_q   <= '0;
      err_q   <= 1'b0;
      hunt_q  <= 1'b0;
    end else begin
      await_q <= await_d;
      cmd_q   <= cmd_d;
      err_q   <= err_d;
      hunt_q  <= hunt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_en) mode_q <= mode_t'(wdata);
  end

  assign mode       = mode_q;
  assign mode_valid = ~await_q;
  assign cmd        = cmd_q;
  assign err_clr    = err_q;
  assign hunt_req   = hunt_q;

endmodule

// File: rtl/usart_stat.sv
module usart_stat
  import usart_if_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_char,
  input  logic              rx_perr,
  input  logic              rx_ferr,
  input  logic              data_rd_done,
  input  logic              err_clr,
  input  logic              data_wr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              tx_take,
  input  logic              tx_idle,
  input  logic              dsr,
  input  logic              syndet,
  output logic [BYTE_W-1:0] rx_buf,
  output status_t           status,
  output logic [BYTE_W-1:0] tx_buf,
  output logic              tx_full
);

  logic              rx_accept;
  logic              rxrdy_q, rxrdy_d;
  logic              pe_q, pe_d, oe_q, oe_d, fe_q, fe_d;
  logic              full_q, full_d;
  logic [BYTE_W-1:0] rxb_q, txb_q;

  always_comb begin
    rx_accept = rx_valid & rx_en;

    rxrdy_d = rxrdy_q;
    if (rx_accept)         rxrdy_d = 1'b1;
    else if (data_rd_done) rxrdy_d = 1'b0;

    // a set in the same cycle as a clear wins
    pe_d = (pe_q & ~err_clr) | (rx_accept & rx_perr);
    fe_d = (fe_q & ~err_clr) | (rx_accept & rx_ferr);
    oe_d = (oe_q & ~err_clr) | (rx_accept & rxrdy_q & ~data_rd_done);

    full_d = full_q;
    if (data_wr)      full_d = 1'b1;
    else if (tx_take) full_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxrdy_q <= 1'b0;
      pe_q    <= 1'b0;
      oe_q    <= 1'b0;
      fe_q    <= 1'b0;
      full_q  <= 1'b0;
    end else begin
      rxrdy_q <= rxrdy_d;
      pe_q    <= pe_d;
      oe_q    <= oe_d;
      fe_q    <= fe_d;
      full_q  <= full_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rxb_q <= '0;
    else if (rx_accept) rxb_q <= rx_char;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       txb_q <= '0;
    else if (data_wr) txb_q <= wdata;
  end

  always_comb begin
    status.dsr     = dsr;
    status.syndet  = syndet;
    status.fe      = fe_q;
    status.oe      = oe_q;
    status.pe      = pe_q;
    status.txempty = ~full_q & tx_idle;
    status.rxrdy   = rxrdy_q;
    status.txrdy   = ~full_q;
  end

  assign rx_buf  = rxb_q;
  assign tx_buf  = txb_q;
  assign tx_full = full_q;

endmodule

// File: rtl/usart_cpu_if.sv
module usart_cpu_if
  import usart_if_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic       cd,
  input  logic [7:0] din,
  output logic [7:0] dout,
  output logic [1:0] stop_bits,
  output logic       parity_even,
  output logic       parity_en,
  output logic [1:0] char_len,
  output logic [1:0] clk_factor,
  output logic       mode_valid,
  output logic       tx_en,
  output logic       rx_en,
  output logic       send_brk,
  output logic       err_clr,
  output logic       hunt_req,
  output logic       dtr_n,
  output logic       rts_n,
  output logic [7:0] tx_hold_data,
  output logic       tx_hold_valid,
  input  logic       tx_take,
  input  logic       tx_idle,
  input  logic       rx_valid,
  input  logic [7:0] rx_char,
  input  logic       rx_perr,
  input  logic       rx_ferr,
  input  logic       dsr_n,
  input  logic       syndet
);

  logic              rst_sync_n;
  logic              ctrl_wr, data_wr, rd_ctrl_sel, rd_data_sel, data_rd_done;
  logic              dsr_n_sync;
  mode_t             mode;
  cmd_t              cmd;
  status_t           status;
  logic [BYTE_W-1:0] status_byte;
  logic [BYTE_W-1:0] rx_buf;

  usart_rst_sync #(.STAGES(RST_STAGES)) i_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  usart_sync_bit #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_dsr_sync (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .d    (dsr_n),
    .q    (dsr_n_sync)
  );

  usart_bus_ctl i_bus (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .cs_n        (cs_n),
    .rd_n        (rd_n),
    .wr_n        (wr_n),
    .cd          (cd),
    .ctrl_wr     (ctrl_wr),
    .data_wr     (data_wr),
    .rd_ctrl_sel (rd_ctrl_sel),
    .rd_data_sel (rd_data_sel),
    .data_rd_done(data_rd_done)
  );

  usart_ctrl_regs i_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .ctrl_wr   (ctrl_wr),
    .wdata     (din),
    .mode      (mode),
    .mode_valid(mode_valid),
    .cmd       (cmd),
    .err_clr   (err_clr),
    .hunt_req  (hunt_req)
  );

  usart_stat i_stat (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .rx_en       (cmd.rx_en),
    .rx_valid    (rx_valid),
    .rx_char     (rx_char),
    .rx_perr     (rx_perr),
    .rx_ferr     (rx_ferr),
    .data_rd_done(data_rd_done),
    .err_clr     (err_clr),
    .data_wr     (data_wr),
    .wdata       (din),
    .tx_take     (tx_take),
    .tx_idle     (tx_idle),
    .dsr         (~dsr_n_sync),
    .syndet      (syndet),
    .rx_buf      (rx_buf),
    .status      (status),
    .tx_buf      (tx_hold_data),
    .tx_full     (tx_hold_valid)
  );

  assign status_byte = status;

  always_comb begin
    if (rd_ctrl_sel)      dout = status_byte;
    else if (rd_data_sel) dout = rx_buf;
    else                  dout = '0;
  end

  assign stop_bits   = mode.stop;
  assign parity_even = mode.par_even;
  assign parity_en   = mode.par_en;
  assign char_len    = mode.len;
  assign clk_factor  = mode.factor;
  assign tx_en       = cmd.tx_en;
  assign rx_en       = cmd.rx_en;
  assign send_brk    = cmd.brk;
  assign dtr_n       = ~cmd.dtr;
  assign rts_n       = ~cmd.rts;

endmodule

// File: rtl/usart_cpu_if_chk.sv
module usart_cpu_if_chk (
  input logic       clk,
  input logic       rst_ni,
  input logic       cs_n,
  input logic       rd_n,
  input logic       ctrl_wr,
  input logic       data_wr,
  input logic       data_rd_done,
  input logic [7:0] wdata,
  input logic [7:0] dout,
  input logic [7:0] status,
  input logic       mode_valid,
  input logic       tx_en,
  input logic       rx_en,
  input logic       dtr_n,
  input logic       rts_n,
  input logic       err_clr,
  input logic       tx_hold_valid,
  input logic       rx_valid
);

  p_mode_first_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (ctrl_wr && !mode_valid) |=> mode_valid);

  p_modem_lines_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    (ctrl_wr && mode_valid && !wdata[6]) |=>
      (dtr_n == !$past(wdata[1])) && (rts_n == !$past(wdata[5])));

  p_int_reset_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (ctrl_wr && mode_valid && wdata[6]) |=>
      (!mode_valid && !tx_en && !rx_en && dtr_n && rts_n));

  p_err_pulse_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    err_clr |=> !err_clr);

  p_err_clears_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (err_clr && !rx_valid) |=> (status[5:3] == 3'b000));

  p_tx_load_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    data_wr |=> tx_hold_valid);

  p_rxrdy_hold_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    (!rx_valid && !data_rd_done) |=> $stable(status[1]));

  p_overrun_r12: assert property (@(posedge clk) disable iff (!rst_ni)
    (rx_valid && rx_en && status[1] && !data_rd_done) |=> status[4]);

  p_bus_idle_r14: assert property (@(posedge clk) disable iff (!rst_ni)
    (cs_n || !rd_n == 1'b0) |-> (dout == 8'h00));

endmodule

bind usart_cpu_if usart_cpu_if_chk i_chk (
  .clk          (clk),
  .rst_ni       (rst_sync_n),
  .cs_n         (cs_n),
  .rd_n         (rd_n),
  .ctrl_wr      (ctrl_wr),
  .data_wr      (data_wr),
  .data_rd_done (data_rd_done),
  .wdata        (din),
  .dout         (dout),
  .status       (status_byte),
  .mode_valid   (mode_valid),
  .tx_en        (tx_en),
  .rx_en        (rx_en),
  .dtr_n        (dtr_n),
  .rts_n        (rts_n),
  .err_clr      (err_clr),
  .tx_hold_valid(tx_hold_valid),
  .rx_valid     (rx_valid)
);

// File: tb/test_usart_cpu_if.sv
`timescale 1ns/1ps
module test_usart_cpu_if;

  logic       clk = 1'b0;
  logic       rst_n, cs_n, rd_n, wr_n, cd;
  logic [7:0] din, dout;
  logic [1:0] stop_bits, char_len, clk_factor;
  logic       parity_even, parity_en, mode_valid;
  logic       tx_en, rx_en, send_brk, err_clr, hunt_req, dtr_n, rts_n;
  logic [7:0] tx_hold_data;
  logic       tx_hold_valid, tx_take, tx_idle;
  logic       rx_valid, rx_perr, rx_ferr, dsr_n, syndet;
  logic [7:0] rx_char;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  usart_cpu_if #(.SYNC_STAGES(3), .RST_STAGES(2)) i_usart_cpu_if (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .cd(cd),
    .din(din), .dout(dout), .stop_bits(stop_bits), .parity_even(parity_even),
    .parity_en(parity_en), .char_len(char_len), .clk_factor(clk_factor),
    .mode_valid(mode_valid), .tx_en(tx_en), .rx_en(rx_en), .send_brk(send_brk),
    .err_clr(err_clr), .hunt_req(hunt_req), .dtr_n(dtr_n), .rts_n(rts_n),
    .tx_hold_data(tx_hold_data), .tx_hold_valid(tx_hold_valid),
    .tx_take(tx_take), .tx_idle(tx_idle), .rx_valid(rx_valid),
    .rx_char(rx_char), .rx_perr(rx_perr), .rx_ferr(rx_ferr),
    .dsr_n(dsr_n), .syndet(syndet)
  );

  // {mode byte, clock factor, data bits, stop half-bits, parity 0 none/1 odd/2 even}
  localparam logic [31:0] MODE_VEC [5] = '{
    32'h4E_10_8_2_00,
    32'hFB_40_7_4_02,
    32'h90_00_5_3_01,
    32'h7D_01_8_2_02,
    32'hC6_10_6_4_00
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic sel, input logic [7:0] d, input logic en);
    @(negedge clk);
    cs_n = ~en; cd = sel; din = d; wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1; cs_n = 1'b1;
  endtask

  task automatic bus_rd(input logic sel, input logic en, output logic [7:0] d);
    @(negedge clk);
    cs_n = ~en; cd = sel; rd_n = 1'b0;
    @(negedge clk);
    d = dout;
    rd_n = 1'b1; cs_n = 1'b1;
  endtask

  task automatic rx_send(input logic [7:0] ch, input logic pe, input logic fe);
    @(negedge clk);
    rx_valid = 1'b1; rx_char = ch; rx_perr = pe; rx_ferr = fe;
    @(negedge clk);
    rx_valid = 1'b0; rx_perr = 1'b0; rx_ferr = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R1 watchdog: actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] rd;
    logic [7:0] stop_h, par, bits, fac;
    rst_n = 1'b0; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; cd = 1'b0; din = '0;
    tx_take = 1'b0; tx_idle = 1'b1; rx_valid = 1'b0; rx_char = '0;
    rx_perr = 1'b0; rx_ferr = 1'b0; dsr_n = 1'b1; syndet = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 mode_valid in reset", {7'd0, mode_valid}, 8'h00);
    chk("R1 dtr_n/rts_n in reset", {6'd0, dtr_n, rts_n}, 8'h03);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 enables after reset", {5'd0, tx_en, rx_en, send_brk}, 8'h00);
    chk("R1 mode_valid after reset", {7'd0, mode_valid}, 8'h00);
    bus_rd(1'b1, 1'b1, rd);
    chk("R1 R13 reset status", rd, 8'h05);

    // R3 R6: table of mode bytes, each after an internal reset
    for (int i = 0; i < 5; i++) begin
      if (i > 0) begin
        bus_wr(1'b1, 8'h40, 1'b1);
        chk("R6 internal reset awaits mode", {7'd0, mode_valid}, 8'h00);
      end
      bus_wr(1'b1, MODE_VEC[i][31:24], 1'b1);
      stop_h = (stop_bits == 2'd1) ? 8'd2 : (stop_bits == 2'd2) ? 8'd3 :
               (stop_bits == 2'd3) ? 8'd4 : 8'd0;
      par    = !parity_en ? 8'd0 : (parity_even ? 8'd2 : 8'd1);
      bits   = 8'd5 + {6'd0, char_len};
      fac    = (clk_factor == 2'd0) ? 8'd0 : (clk_factor == 2'd1) ? 8'd1 :
               (clk_factor == 2'd2) ? 8'd16 : 8'd64;
      chk("R3 mode_valid", {7'd0, mode_valid}, 8'h01);
      chk("R3 stop", stop_h, {4'd0, MODE_VEC[i][11:8]});
      chk("R3 parity", par, MODE_VEC[i][7:0]);
      chk("R3 bits", bits, {4'd0, MODE_VEC[i][15:12]});
      chk("R3 factor", fac, MODE_VEC[i][23:16]);
      chk("R4 enables unchanged by mode", {5'd0, tx_en, rx_en, send_brk}, 8'h00);
    end

    // R2: deselected write and read
    bus_wr(1'b1, 8'h27, 1'b0);
    chk("R2 deselected command ignored", {6'd0, tx_en, rx_en}, 8'h00);
    bus_wr(1'b0, 8'h99, 1'b0);
    chk("R2 deselected data write ignored", {7'd0, tx_hold_valid}, 8'h00);
    bus_rd(1'b1, 1'b0, rd);
    chk("R2 R14 deselected read", rd, 8'h00);

    // R4 R5
    bus_wr(1'b1, 8'h27, 1'b1);
    chk("R4 tx/rx/brk", {5'd0, tx_en, rx_en, send_brk}, 8'h06);
    chk("R5 dtr_n/rts_n low", {6'd0, dtr_n, rts_n}, 8'h00);
    chk("R4 mode kept", {6'd0, stop_bits}, 8'h03);
    bus_wr(1'b1, 8'h08, 1'b1);
    chk("R4 break only", {5'd0, tx_en, rx_en, send_brk}, 8'h01);
    chk("R5 dtr_n/rts_n high", {6'd0, dtr_n, rts_n}, 8'h03);

    // R10: ignored while receive disabled
    rx_send(8'hA5, 1'b0, 1'b0);
    bus_rd(1'b1, 1'b1, rd);
    chk("R10 char ignored when rx disabled", rd, 8'h05);

    bus_wr(1'b1, 8'h27, 1'b1);
    rx_send(8'h3C, 1'b1, 1'b0);
    bus_rd(1'b1, 1'b1, rd);
    chk("R10 R12 rxrdy and parity", rd, 8'h0F);
    bus_rd(1'b0, 1'b1, rd);
    chk("R11 data read", rd, 8'h3C);
    bus_rd(1'b1, 1'b1, rd);
    chk("R11 rxrdy cleared", rd, 8'h0D);

    // R12 overrun and framing
    rx_send(8'h11, 1'b0, 1'b0);
    rx_send(8'h22, 1'b0, 1'b1);
    bus_rd(1'b1, 1'b1, rd);
    chk("R12 overrun/framing", rd, 8'h3F);
    bus_rd(1'b0, 1'b1, rd);
    chk("R11 newest char", rd, 8'h22);

    // R7 error reset
    bus_wr(1'b1, 8'h37, 1'b1);
    chk("R7 err_clr pulse", {7'd0, err_clr}, 8'h01);
    @(negedge clk);
    chk("R7 err_clr one cycle", {7'd0, err_clr}, 8'h00);
    bus_rd(1'b1, 1'b1, rd);
    chk("R7 flags cleared", rd, 8'h05);
    chk("R7 R4 enables kept", {6'd0, tx_en, rx_en}, 8'h03);
    rx_send(8'h5E, 1'b1, 1'b0);
    bus_rd(1'b1, 1'b1, rd);
    chk("R7 not latched, parity sets again", rd, 8'h0F);
    bus_rd(1'b0, 1'b1, rd);
    bus_wr(1'b1, 8'h37, 1'b1);

    // R8 hunt
    bus_wr(1'b1, 8'h87, 1'b1);
    chk("R8 hunt pulse", {7'd0, hunt_req}, 8'h01);
    chk("R5 rts_n released", {6'd0, dtr_n, rts_n}, 8'h01);
    @(negedge clk);
    chk("R8 hunt one cycle", {7'd0, hunt_req}, 8'h00);

    // R9 transmit holding
    bus_wr(1'b0, 8'h5A, 1'b1);
    chk("R9 hold data", tx_hold_data, 8'h5A);
    chk("R9 hold valid", {7'd0, tx_hold_valid}, 8'h01);
    bus_rd(1'b1, 1'b1, rd);
    chk("R9 status while held", rd, 8'h00);
    @(negedge clk);
    tx_take = 1'b1; tx_idle = 1'b0;
    @(negedge clk);
    tx_take = 1'b0;
    bus_rd(1'b1, 1'b1, rd);
    chk("R9 taken, shifter busy", rd, 8'h01);
    tx_idle = 1'b1;
    bus_rd(1'b1, 1'b1, rd);
    chk("R9 empty", rd, 8'h05);

    // R13 modem input latency and sync flag
    dsr_n = 1'b0;
    bus_rd(1'b1, 1'b1, rd);
    chk("R13 dsr not yet through", rd, 8'h05);
    bus_rd(1'b1, 1'b1, rd);
    chk("R13 dsr visible", rd, 8'h85);
    syndet = 1'b1;
    bus_rd(1'b1, 1'b1, rd);
    chk("R13 syndet", rd, 8'hC5);

    // R14 idle bus
    @(negedge clk);
    rd_n = 1'b0; cs_n = 1'b1;
    #1 chk("R14 dout idle", dout, 8'h00);
    rd_n = 1'b1;

    // R6 final internal reset
    bus_wr(1'b1, 8'h23, 1'b1);
    bus_wr(1'b1, 8'h40, 1'b1);
    chk("R6 commands cleared", {4'd0, tx_en, rx_en, dtr_n, rts_n}, 8'h03);
    chk("R6 awaiting mode", {7'd0, mode_valid}, 8'h00);

    finish_run();
  end

endmodule